// File: doc/BRIEF.md
# Interrupt to Transfer-Request Router

This block takes a vector of peripheral interrupt flags and sends each flag to the right consumer. The consumers are a data-transfer engine, reached through a single request channel, and a CPU interrupt request vector. Two per-source control bits decide the route: a transfer-enable bit and a notify-after-transfer bit. A source can be served by the transfer engine alone, by the CPU alone, or first by the transfer engine and then by the CPU. In the transfer-only case the router also pulses a hardware clear back to the source.

When several sources want a transfer at the same time, a fixed priority picks one: the lowest index wins. Only one transfer is outstanding at a time. The request channel is valid/ready. The router holds valid and the source index stable until ready is seen, with one exception: if the requesting flag drops before acceptance, valid is withdrawn in that same cycle. After acceptance, the router starts no new arbitration until the engine pulses `xfer_done`. `xfer_done` is a plain one-cycle input with no back-pressure.

A source whose transfer has completed is marked as served. It is not requested again until its flag goes low. This stops a flag that software or the peripheral has not yet cleared from starting a second transfer.

Top module: `irq_xfer_router`

## Requirements
- R1: When several sources are transfer candidates in the same arbitration cycle, the lowest index is requested first. The CPU-side inputs have no influence on the choice.
- R2: A source with transfer-enable 0 drives its `cpu_irq` bit directly from its flag in the same cycle, whatever its notify bit holds. It never raises a transfer request and never receives a clear pulse.
- R3: A source with transfer-enable 1 and notify 0 is requested for transfer. Its `cpu_irq` bit stays 0. Its `src_clr` bit is high for exactly one cycle: the cycle after the cycle in which `xfer_done` is sampled high.
- R4: A source with transfer-enable 1 and notify 1 is requested for transfer and never receives a clear pulse. Its `cpu_irq` bit is 0 until the transfer completes. It is then 1 from the cycle after `xfer_done` for as long as the flag stays high.
- R5: A candidate flag seen in an idle cycle gives `xreq_valid`=1 in the next cycle. While `xreq_valid`=1 and `xreq_ready`=0, `xreq_idx` holds its value.
- R6: After a handshake (`xreq_valid` and `xreq_ready` both 1), `xreq_valid` stays 0 until `xfer_done` has been seen. The next request can appear at the earliest in the cycle after the cycle following `xfer_done`.
- R7: If the flag of the requested source drops before acceptance, `xreq_valid` falls in that same cycle. Arbitration then restarts, so a still-pending candidate is requested two cycles later.
- R8: A served source is not requested again while its flag stays high. After the flag has been low for at least one cycle, it is requested again.
- R9: A `cpu_irq` bit is never 1 while the flag of that source is 0.
- R10: With `rst_n` low at a clock edge, `xreq_valid`, `src_clr` and all served marks are 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | N_SRC | Peripheral interrupt flags |
| xfer_en | input | N_SRC | Per-source transfer-enable bits |
| irq_after | input | N_SRC | Per-source notify-CPU-after-transfer bits |
| xreq_valid | output | 1 | Transfer request valid |
| xreq_ready | input | 1 | Transfer engine accepts the request |
| xreq_idx | output | IDX_W | Index of the requesting source |
| xfer_done | input | 1 | One-cycle pulse: accepted transfer finished |
| cpu_irq | output | N_SRC | Per-source CPU interrupt requests |
| src_clr | output | N_SRC | One-cycle hardware clear pulses to sources |

## Verification
The bench raises three transfer-only flags at once. It checks that they are served in the order 1, 4, 6. A router with reversed or broken priority would serve them out of order. For a source routed to both consumers, the bench watches `cpu_irq` through the whole transfer. A design that failed to wait would raise it early; one that cleared the flag would pulse `src_clr`. The bench also drops a flag while its request is still unanswered, and holds a served flag high across several idle cycles. A design without withdrawal would leave `xreq_valid` high, and one without the served mark would issue a duplicate transfer.

// File: rtl/irq_xfer_router_pkg.sv
package irq_xfer_router_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_BUSY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] cand,
  output logic             any,
  output logic [IDX_W-1:0] win_idx
);
  logic [N_SRC-1:0] above;  // some lower-index candidate exists
  logic [N_SRC-1:0] gnt;

  assign above[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < N_SRC; g++) begin : g_chain
      assign above[g] = above[g-1] | cand[g-1];
    end
    for (g = 0; g < N_SRC; g++) begin : g_gnt
      assign gnt[g] = cand[g] & ~above[g];
    end
  endgenerate

  assign any = |cand;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (gnt[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] xfer_en,
  input  logic [N_SRC-1:0] irq_after,
  input  logic [N_SRC-1:0] served,
  output logic [N_SRC-1:0] xfer_cand,
  output logic [N_SRC-1:0] cpu_irq
);
  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      // transfer wanted: enabled, flagged, not yet served
      assign xfer_cand[g] = src_flag[g] & xfer_en[g] & ~served[g];
      // CPU path: direct when no transfer, or after a served notify transfer
      assign cpu_irq[g]   = src_flag[g] & (~xfer_en[g] | (irq_after[g] & served[g]));
    end
  endgenerate
endmodule

// File: rtl/irq_xfer_seq.sv
module irq_xfer_seq
  import irq_xfer_router_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] irq_after,
  input  logic             arb_any,
  input  logic [IDX_W-1:0] arb_idx,
  output logic             xreq_valid,
  input  logic             xreq_ready,
  output logic [IDX_W-1:0] xreq_idx,
  input  logic             xfer_done,
  output logic [N_SRC-1:0] served,
  output logic [N_SRC-1:0] src_clr
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             notify_q;
  logic [N_SRC-1:0] served_q;
  logic [N_SRC-1:0] clr_q;
  logic [N_SRC-1:0] idx_onehot;
  logic             fire;
  logic             finish;

  assign idx_onehot = N_SRC'(1) << idx_q;
  assign xreq_valid = (state_q == SEQ_REQ) && src_flag[idx_q];
  assign xreq_idx   = idx_q;
  assign fire       = xreq_valid && xreq_ready;
  assign finish     = (state_q == SEQ_BUSY) && xfer_done;
  assign served     = served_q;
  assign src_clr    = clr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      idx_q    <= '0;
      notify_q <= 1'b0;
      served_q <= '0;
      clr_q    <= '0;
    end else begin
      served_q <= (served_q | (finish ? idx_onehot : '0)) & src_flag;
      clr_q    <= (finish && !notify_q) ? idx_onehot : '0;
      case (state_q)
        SEQ_IDLE: begin
          if (arb_any) begin
            idx_q    <= arb_idx;
            notify_q <= irq_after[arb_idx];
            state_q  <= SEQ_REQ;
          end
        end
        SEQ_REQ: begin
          if (fire)                    state_q <= SEQ_BUSY;
          else if (!src_flag[idx_q])   state_q <= SEQ_IDLE;
        end
        SEQ_BUSY: begin
          if (xfer_done) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_xfer_router.sv
module irq_xfer_router #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_flag,
  input  logic [N_SRC-1:0] xfer_en,
  input  logic [N_SRC-1:0] irq_after,
  output logic             xreq_valid,
  input  logic             xreq_ready,
  output logic [IDX_W-1:0] xreq_idx,
  input  logic             xfer_done,
  output logic [N_SRC-1:0] cpu_irq,
  output logic [N_SRC-1:0] src_clr
);
  logic [N_SRC-1:0] served;
  logic [N_SRC-1:0] xfer_cand;
  logic             arb_any;
  logic [IDX_W-1:0] arb_idx;

  irq_route_decode #(.N_SRC(N_SRC)) u_decode (
    .src_flag (src_flag),
    .xfer_en  (xfer_en),
    .irq_after(irq_after),
    .served   (served),
    .xfer_cand(xfer_cand),
    .cpu_irq  (cpu_irq)
  );

  irq_prio_arbiter #(.N_SRC(N_SRC)) u_arb (
    .cand   (xfer_cand),
    .any    (arb_any),
    .win_idx(arb_idx)
  );

  irq_xfer_seq #(.N_SRC(N_SRC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_flag  (src_flag),
    .irq_after (irq_after),
    .arb_any   (arb_any),
    .arb_idx   (arb_idx),
    .xreq_valid(xreq_valid),
    .xreq_ready(xreq_ready),
    .xreq_idx  (xreq_idx),
    .xfer_done (xfer_done),
    .served    (served),
    .src_clr   (src_clr)
  );
endmodule

// File: rtl/irq_xfer_router_chk.sv
module irq_xfer_router_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_flag,
  input logic [N_SRC-1:0] xfer_en,
  input logic [N_SRC-1:0] irq_after,
  input logic             xreq_valid,
  input logic             xreq_ready,
  input logic [IDX_W-1:0] xreq_idx,
  input logic             xfer_done,
  input logic [N_SRC-1:0] cpu_irq,
  input logic [N_SRC-1:0] src_clr
);
  logic in_flight;

  always_ff @(posedge clk) begin
    if (!rst_n)                        in_flight <= 1'b0;
    else if (xreq_valid && xreq_ready) in_flight <= 1'b1;
    else if (xfer_done)                in_flight <= 1'b0;
  end

  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid && !xreq_ready |=> $stable(xreq_idx));

  p_single_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_flight |-> !xreq_valid);

  p_valid_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xreq_valid |-> src_flag[xreq_idx]);

  p_clr_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |-> $past(xfer_done));

  p_clr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_clr));

  p_no_cpu_xfer_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq & xfer_en & ~irq_after) == '0);

  p_cpu_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq & ~src_flag) == '0);
endmodule

bind irq_xfer_router irq_xfer_router_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_xfer_router_tb.sv
module irq_xfer_router_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_flag = '0;
  logic [N-1:0] xfer_en = '0;
  logic [N-1:0] irq_after = '0;
  logic         xreq_valid;
  logic         xreq_ready = 1'b0;
  logic [2:0]   xreq_idx;
  logic         xfer_done = 1'b0;
  logic [N-1:0] cpu_irq;
  logic [N-1:0] src_clr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_xfer_router #(.N_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .xfer_en(xfer_en),
    .irq_after(irq_after), .xreq_valid(xreq_valid), .xreq_ready(xreq_ready),
    .xreq_idx(xreq_idx), .xfer_done(xfer_done), .cpu_irq(cpu_irq),
    .src_clr(src_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge, then settle just after the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  // wait for a request, check its index, accept it, complete it, check clear
  task automatic run_xfer(input int exp_idx, input bit exp_clr, input string req);
    for (int k = 0; k < 6 && !xreq_valid; k++) tick();
    chk(xreq_valid == 1'b1, req, int'(xreq_valid), 1);
    chk(int'(xreq_idx) == exp_idx, req, int'(xreq_idx), exp_idx);
    xreq_ready = 1'b1;
    tick();
    xreq_ready = 1'b0;
    #1;
    chk(xreq_valid == 1'b0, "R6", int'(xreq_valid), 0);
    tick();
    chk(xreq_valid == 1'b0, "R6", int'(xreq_valid), 0);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    #1;
    chk(src_clr == (exp_clr ? (N'(1) << exp_idx) : '0), exp_clr ? "R3" : "R4",
        int'(src_clr), exp_clr ? (1 << exp_idx) : 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk(xreq_valid == 1'b0, "R10", int'(xreq_valid), 0);
    chk(src_clr == '0, "R10", int'(src_clr), 0);
    chk(cpu_irq == '0, "R10", int'(cpu_irq), 0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_cpu_only();
    xfer_en = '0;
    irq_after = 8'h08;
    src_flag = 8'h08;
    #1;
    chk(cpu_irq == 8'h08, "R2", int'(cpu_irq), 8'h08);
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(xreq_valid == 1'b0 && src_clr == '0, "R2", int'(xreq_valid), 0);
    end
    src_flag = '0;
    #1;
    chk(cpu_irq == '0, "R9", int'(cpu_irq), 0);
    irq_after = '0;
    tick();
  endtask

  task automatic t_xfer_only();
    xfer_en = 8'h20;
    irq_after = 8'h00;
    src_flag = 8'h20;
    tick();
    chk(xreq_valid == 1'b1, "R5", int'(xreq_valid), 1);
    chk(xreq_idx == 3'd5, "R5", int'(xreq_idx), 5);
    tick();
    chk(xreq_valid == 1'b1 && xreq_idx == 3'd5, "R5", int'(xreq_idx), 5);
    chk(cpu_irq == '0, "R3", int'(cpu_irq), 0);
    run_xfer(5, 1'b1, "R3");
    tick();
    chk(src_clr == '0, "R3", int'(src_clr), 0);
    for (int k = 0; k < 4; k++) begin
      chk(xreq_valid == 1'b0, "R8", int'(xreq_valid), 0);
      chk(cpu_irq == '0, "R3", int'(cpu_irq), 0);
      tick();
    end
    src_flag = '0;
    tick();
    src_flag = 8'h20;
    tick();
    chk(xreq_valid == 1'b1 && xreq_idx == 3'd5, "R8", int'(xreq_valid), 1);
    run_xfer(5, 1'b1, "R8");
    src_flag = '0;
    tick();
  endtask

  task automatic t_both();
    xfer_en = 8'h04;
    irq_after = 8'h04;
    src_flag = 8'h04;
    #1;
    chk(cpu_irq == '0, "R4", int'(cpu_irq), 0);
    tick();
    chk(xreq_valid == 1'b1 && xreq_idx == 3'd2, "R4", int'(xreq_idx), 2);
    xreq_ready = 1'b1;
    tick();
    xreq_ready = 1'b0;
    tick();
    chk(cpu_irq == '0, "R4", int'(cpu_irq), 0);
    xfer_done = 1'b1;
    tick();
    xfer_done = 1'b0;
    #1;
    chk(cpu_irq == 8'h04, "R4", int'(cpu_irq), 8'h04);
    chk(src_clr == '0, "R4", int'(src_clr), 0);
    tick();
    chk(cpu_irq == 8'h04 && src_clr == '0 && !xreq_valid, "R4", int'(cpu_irq), 8'h04);
    src_flag = '0;
    #1;
    chk(cpu_irq == '0, "R9", int'(cpu_irq), 0);
    tick();
  endtask

  task automatic t_priority();
    xfer_en = 8'h52;
    irq_after = '0;
    src_flag = 8'h52;  // sources 1, 4, 6
    run_xfer(1, 1'b1, "R1");
    run_xfer(4, 1'b1, "R1");
    run_xfer(6, 1'b1, "R1");
    src_flag = '0;
    tick();
  endtask

  task automatic t_withdraw();
    xfer_en = 8'h90;
    irq_after = '0;
    src_flag = 8'h80;
    tick();
    chk(xreq_valid == 1'b1 && xreq_idx == 3'd7, "R7", int'(xreq_idx), 7);
    src_flag = 8'h10;
    #1;
    chk(xreq_valid == 1'b0, "R7", int'(xreq_valid), 0);
    tick();
    chk(xreq_valid == 1'b0, "R7", int'(xreq_valid), 0);
    tick();
    chk(xreq_valid == 1'b1 && xreq_idx == 3'd4, "R7", int'(xreq_idx), 4);
    run_xfer(4, 1'b1, "R7");
    src_flag = '0;
    xfer_en = '0;
    tick();
  endtask

  initial begin
    for (int c = 0; c < 5000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cpu_only();
    t_xfer_only();
    t_both();
    t_priority();
    t_withdraw();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule